// File: doc/BRIEF.md
# Keyed Single-Use Write Gate

This block sits on the write path in front of a register file. It decides whether each bus write to a protected register may go through. Software opens the gate by writing a key word to a dedicated arming register. That word names the one register offset that may be written next. The opening is used up by the very next bus write, whatever that write targets. Any protected write that finds the gate closed, or aimed at another offset, is dropped. Such a write raises a sticky error flag.

The register file supplies a one-bit "this address is protected" lookup for the current write address. The gate returns a same-cycle permit strobe, which the register file uses as its write enable. The gate owns two addresses of its own:

- the arming register;
- the error-status register, where software writes a one to bit 0 to clear the flag.

Top module: `keyed_write_gate`

## Requirements
- R1: After reset the gate is closed and `err_flag` is 0. While `wr_en` is low, `wr_permit` is 0.
- R2: A write to `ARM_ADDR` whose data bits [31:24] equal 8'hAA opens the gate. It stores data bits [9:0] as the single offset that may be written next. Writes to `ARM_ADDR` or `STAT_ADDR` never assert `wr_permit`.
- R3: A write with `wr_prot`=1 gets `wr_permit`=1 in the same cycle only if the gate is open and the stored offset equals `wr_addr`.
- R4: Any write other than an arming write closes the gate from the next cycle on. This holds whether or not the write hit the stored offset.
- R5: A write with `wr_prot`=1 that R3 denies gets `wr_permit`=0, and `err_flag` reads 1 from the next cycle.
- R6: An arming write whose bits [31:24] differ from 8'hAA closes the gate and sets `err_flag` from the next cycle.
- R7: A write with `wr_prot`=0 to any address other than the gate's own two gets `wr_permit`=1, and it still closes the gate.
- R8: `err_flag` stays at 1 until a write to `STAT_ADDR` with data bit 0 set. That write clears it from the next cycle. A write to `STAT_ADDR` with bit 0 clear leaves the flag unchanged.
- R9: A valid arming write while the gate is already open replaces the stored offset. Only the newest offset is then writable.
- R10: Cycles with `wr_en`=0 change neither the gate state nor `err_flag`, whatever `wr_prot`, `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| wr_prot | input | 1 | The register file's lookup: the current address is protected |
| wr_permit | output | 1 | Combinational write enable for the register file |
| err_flag | output | 1 | Sticky access-error flag |

## Verification
Two functions can land on one write. The first is consuming a pending opening and re-opening it with a fresh arming write. The second is closing the gate and raising the error on a bad key while it is open. The bench provokes both:

- it issues an arming write, then a second arming write to a different offset;
- it issues an arming write, then one with a wrong key.

After each, a protected write goes to each offset. A cycle-accurate model in the bench judges every cycle. Per R9 only the newest offset may pass. Per R6 the bad key must leave the gate shut and the flag raised.

// File: rtl/kgate_pkg.sv
package kgate_pkg;

  localparam int DATA_W   = 32;
  localparam int OFF_W    = 10;
  localparam int KEY_LSB  = 24;
  localparam int KEY_W    = 8;
  localparam logic [KEY_W-1:0] KEY_VALUE = 8'hAA;

  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_ARM    = 2'd1,
    WK_STATUS = 2'd2,
    WK_TARGET = 2'd3
  } wr_kind_e;

  // key field of an arming word
  function automatic logic key_good(input logic [DATA_W-1:0] d);
    return d[KEY_LSB +: KEY_W] == KEY_VALUE;
  endfunction

  // offset field of an arming word
  function automatic logic [OFF_W-1:0] arm_offset(input logic [DATA_W-1:0] d);
    return d[OFF_W-1:0];
  endfunction

endpackage

// File: rtl/kgate_classify.sv
module kgate_classify
  import kgate_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] ARM_ADDR  = '1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
  parameter int CLR_BIT = 0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_prot,
  input  logic              armed,
  input  logic [OFF_W-1:0]  armed_off,
  output wr_kind_e          kind,
  output logic              permit,
  output logic              arm_ok,
  output logic              arm_bad,
  output logic              violation,
  output logic              clear_req
);

  logic [ADDR_W-1:0] off_ext;
  logic              hit;

  assign off_ext = ADDR_W'(armed_off);
  assign hit     = armed && (off_ext == wr_addr);

  always_comb begin
    if (!wr_en)                    kind = WK_IDLE;
    else if (wr_addr == ARM_ADDR)  kind = WK_ARM;
    else if (wr_addr == STAT_ADDR) kind = WK_STATUS;
    else                           kind = WK_TARGET;
  end

  always_comb begin
    permit    = 1'b0;
    arm_ok    = 1'b0;
    arm_bad   = 1'b0;
    violation = 1'b0;
    clear_req = 1'b0;
    unique case (kind)
      WK_ARM: begin
        arm_ok  = key_good(wr_data);
        arm_bad = !key_good(wr_data);
      end
      WK_STATUS: clear_req = wr_data[CLR_BIT];
      WK_TARGET: begin
        permit    = !wr_prot || hit;
        violation = wr_prot && !hit;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/kgate_arm_reg.sv
module kgate_arm_reg
  import kgate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             disarm,
  input  logic [OFF_W-1:0] new_off,
  output logic             armed,
  output logic [OFF_W-1:0] armed_off
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      armed_off <= '0;
    end else if (arm) begin
      armed     <= 1'b1;
      armed_off <= new_off;
    end else if (disarm) begin
      armed     <= 1'b0;
    end
  end

endmodule

// File: rtl/kgate_err_flag.sv
module kgate_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_err,
  input  logic clr_err,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_err) flag <= 1'b1;
    else if (clr_err) flag <= 1'b0;
  end

endmodule

// File: rtl/keyed_write_gate.sv
module keyed_write_gate
  import kgate_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] ARM_ADDR  = 10'h3F0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 10'h3F4,
  parameter int CLR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              wr_prot,
  output logic              wr_permit,
  output logic              err_flag
);

  wr_kind_e         kind;
  logic             armed;
  logic [OFF_W-1:0] armed_off;
  logic             ev_arm_ok;
  logic             ev_arm_bad;
  logic             ev_violation;
  logic             ev_clear;
  logic             ev_consume;
  logic             ev_set_err;

  kgate_classify #(
    .ADDR_W(ADDR_W), .ARM_ADDR(ARM_ADDR),
    .STAT_ADDR(STAT_ADDR), .CLR_BIT(CLR_BIT)
  ) cls_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_prot(wr_prot), .armed(armed), .armed_off(armed_off),
    .kind(kind), .permit(wr_permit), .arm_ok(ev_arm_ok),
    .arm_bad(ev_arm_bad), .violation(ev_violation), .clear_req(ev_clear)
  );

  // every write except a good arming write closes the gate
  assign ev_consume = (kind != WK_IDLE) && !ev_arm_ok;
  assign ev_set_err = ev_violation || ev_arm_bad;

  kgate_arm_reg arm_i (
    .clk(clk), .rst_n(rst_n), .arm(ev_arm_ok), .disarm(ev_consume),
    .new_off(arm_offset(wr_data)), .armed(armed), .armed_off(armed_off)
  );

  kgate_err_flag err_i (
    .clk(clk), .rst_n(rst_n), .set_err(ev_set_err),
    .clr_err(ev_clear), .flag(err_flag)
  );

endmodule

// File: rtl/kgate_checker.sv
module kgate_checker
  import kgate_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] ARM_ADDR  = 10'h3F0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 10'h3F4,
  parameter int CLR_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_prot,
  input logic              wr_permit,
  input logic              err_flag,
  input logic              armed,
  input logic [OFF_W-1:0]  armed_off
);

  logic own_addr;
  assign own_addr = (wr_addr == ARM_ADDR) || (wr_addr == STAT_ADDR);

  AST_IDLE_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_permit); // R1
  AST_OWN_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && own_addr) |-> !wr_permit); // R2
  AST_GOOD_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ARM_ADDR && wr_data[31:24] == 8'hAA)
    |=> (armed && armed_off == $past(wr_data[OFF_W-1:0]))); // R9
  AST_PROT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_permit && wr_prot) |-> (armed && ADDR_W'(armed_off) == wr_addr)); // R3
  AST_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ARM_ADDR) |=> !armed); // R4
  AST_DENY_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !own_addr && wr_prot && !wr_permit) |=> err_flag); // R5
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ARM_ADDR && wr_data[31:24] != 8'hAA)
    |=> (err_flag && !armed)); // R6
  AST_UNPROT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !own_addr && !wr_prot) |-> wr_permit); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == STAT_ADDR && wr_data[CLR_BIT]) |=> !err_flag); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(wr_en && wr_addr == STAT_ADDR && wr_data[CLR_BIT]))
    |=> err_flag); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(armed) && $stable(err_flag))); // R10

endmodule

bind keyed_write_gate kgate_checker #(
  .ADDR_W(ADDR_W), .ARM_ADDR(ARM_ADDR),
  .STAT_ADDR(STAT_ADDR), .CLR_BIT(CLR_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_prot(wr_prot), .wr_permit(wr_permit),
  .err_flag(err_flag), .armed(armed), .armed_off(armed_off)
);

// File: tb/keyed_write_gate_tb.sv
module keyed_write_gate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] A_ARM  = 10'h3F0;
  localparam logic [9:0] A_STAT = 10'h3F4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic       wr_prot = 1'b0;
  logic       wr_permit;
  logic       err_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit       m_open = 1'b0;
  int       m_off = 0;
  bit       m_err = 1'b0;

  keyed_write_gate dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_prot(wr_prot),
    .wr_permit(wr_permit), .err_flag(err_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, compare mid-cycle, then advance model
  task automatic step(input bit we, input logic [9:0] a, input logic [31:0] d,
                      input bit p, input string tag);
    bit exp_permit;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; wr_prot = p;
    #1;
    if (!we || a == A_ARM || a == A_STAT) exp_permit = 1'b0;
    else if (!p)                          exp_permit = 1'b1;
    else exp_permit = m_open && (m_off == int'(a));
    check(tag, "permit", wr_permit, exp_permit);
    check(tag, "err", err_flag, m_err);
    if (we) begin
      if (a == A_ARM) begin
        if (d[31:24] == 8'hAA) begin m_open = 1'b1; m_off = int'(d[9:0]); end
        else begin m_open = 1'b0; m_err = 1'b1; end
      end else begin
        m_open = 1'b0;
        if (a == A_STAT) begin
          if (d[0]) m_err = 1'b0;
        end else if (p && !exp_permit) m_err = 1'b1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", "reset err", err_flag, 1'b0);
    rst_n = 1'b1;
    step(0, 10'h010, 32'h0, 1, "R1");
    // locked protected write is dropped and flagged
    step(1, 10'h010, 32'h1234, 1, "R5");
    step(0, 10'h000, 32'h0, 0, "R5");
    // status write with bit0 clear leaves flag, bit0 set clears
    step(1, A_STAT, 32'hFFFF_FFFE, 0, "R8");
    step(1, A_STAT, 32'h1, 0, "R8");
    step(0, 10'h000, 32'h0, 0, "R8");
    // arm and use once
    step(1, A_ARM, 32'hAA00_0010, 0, "R2");
    step(1, 10'h010, 32'h5, 1, "R3");
    step(1, 10'h010, 32'h6, 1, "R4");
    step(1, A_STAT, 32'h1, 0, "R8");
    // open at one offset, write another: both then denied
    step(1, A_ARM, 32'hAA00_0020, 0, "R2");
    step(1, 10'h010, 32'h7, 1, "R3");
    step(1, 10'h020, 32'h8, 1, "R4");
    step(1, A_STAT, 32'h1, 0, "R8");
    // unprotected write passes and consumes
    step(1, A_ARM, 32'hAA00_0020, 0, "R2");
    step(1, 10'h030, 32'h9, 0, "R7");
    step(1, 10'h020, 32'hA, 1, "R7");
    step(1, A_STAT, 32'h1, 0, "R8");
    // idle cycles with junk keep gate open
    step(1, A_ARM, 32'hAA00_0040, 0, "R2");
    step(0, A_ARM, 32'h5500_0000, 1, "R10");
    step(0, 10'h040, 32'hFFFF_FFFF, 1, "R10");
    step(1, 10'h040, 32'hB, 1, "R10");
    // re-arm replaces offset
    step(1, A_ARM, 32'hAA00_0010, 0, "R9");
    step(1, A_ARM, 32'hAA00_0020, 0, "R9");
    step(1, 10'h020, 32'hC, 1, "R9");
    step(1, A_ARM, 32'hAA00_0010, 0, "R9");
    step(1, A_ARM, 32'hAA00_0020, 0, "R9");
    step(1, 10'h010, 32'hD, 1, "R9");
    step(1, A_STAT, 32'h1, 0, "R8");
    // bad key while open
    step(1, A_ARM, 32'hAA00_0010, 0, "R6");
    step(1, A_ARM, 32'h5500_0010, 0, "R6");
    step(1, 10'h010, 32'hE, 1, "R6");
    step(0, 10'h000, 32'h0, 0, "R6");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule